// File: doc/BRIEF.md
# Logical Instruction Condition Code Unit

This block derives the two-bit condition code produced by the logical instruction group and keeps it in a register where later branch-on-condition logic can test it. Each instruction class has its own rule for turning a result into a code from 0 to 3. The block evaluates the operands presented with a class select when a load strobe is raised. The new code appears in the register after the next rising clock edge.

The memory-walking instructions are sequenced elsewhere. For translate-and-test and for edit and edit-and-mark, the sequencer reports the outcome as a small status word, and this block only maps that status to a code. For test-and-set, the block also supplies the byte to be stored back, with a write enable, in the same cycle that the code is computed.

Top module: `logic_cc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cc_o` is 0 until the first load of a code-setting class.
- R2: Class codes on `class_i` are: 1 AND, 2 OR, 3 XOR, 4 compare, 5 test-under-mask, 6 translate-and-test, 7 test-and-set, 8 edit. `cc_o` takes a new value only on the clock edge after `load_i` is high with one of these classes. With `load_i` low, or with class 0 or 9 to 15, `cc_o` keeps its value.
- R3: For AND, OR and XOR, the result of `opa_i` op `opb_i` is formed, and the code is 0 when that result is all zeros and 1 otherwise.
- R4: For compare, the operands are treated as unsigned. The code is 0 when they are equal, 1 when `opa_i` is lower and 2 when `opa_i` is higher.
- R5: For test-under-mask, the bits of `opa_i[7:0]` selected by ones in `tm_mask_i` are tested. The code is 0 when all selected bits are zero, 1 when they are mixed and 3 when all of them are one.
- R6: For test-under-mask, a mask of all zeros gives code 0.
- R7: For translate-and-test, `trt_stat_i` = {found, at_last}. The code is 0 when found is 0, 1 when found is 1 and at_last is 0, and 2 when both bits are 1.
- R8: For test-and-set, the code is 0 when `ts_byte_i[7]` is 0 and 1 when it is 1.
- R9: `ts_wr_o` is high, and `ts_wb_o` is 8'hFF, in the same cycle as a load of test-and-set. At all other times `ts_wr_o` is low.
- R10: For edit, `edit_stat_i` = {nonzero, negative}. The code is 0 when nonzero is 0, 1 when the field is nonzero and negative, and 2 when it is nonzero and not negative.
- R11: Code 3 is never produced by AND, XOR, compare or test-and-set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Evaluate and capture the code this cycle |
| class_i | input | 4 | Instruction class select |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| tm_mask_i | input | 8 | Test-under-mask selection mask |
| ts_byte_i | input | 8 | Byte fetched by test-and-set |
| trt_stat_i | input | 2 | Translate-and-test scan status {found, at_last} |
| edit_stat_i | input | 2 | Edit result status {nonzero, negative} |
| cc_o | output | 2 | Condition code register |
| ts_wb_o | output | 8 | Byte to write back for test-and-set |
| ts_wr_o | output | 1 | Write-back enable for test-and-set |

## Verification
Test-under-mask is the hardest case to cover, because the outcome depends on how the operand byte and the mask relate to each other. The stimulus therefore covers a mask of all zeros, a single-bit mask set and clear, and full and partial masks with all-one, all-zero and mixed selected bits. Hold behaviour is checked by placing idle cycles and loads of reserved classes between code-setting loads with opposite outcomes. A missed hold then shows up as a changed code. Compare is driven at the unsigned extremes, where a signed comparison would give a different result.

// File: rtl/logic_cc_unit.sv
module logic_cc_unit #(
  parameter int DW = 32,
  parameter int MW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [3:0]    class_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [MW-1:0] tm_mask_i,
  input  logic [BW-1:0] ts_byte_i,
  input  logic [1:0]    trt_stat_i,
  input  logic [1:0]    edit_stat_i,
  output logic [1:0]    cc_o,
  output logic [BW-1:0] ts_wb_o,
  output logic          ts_wr_o
);
  localparam logic [3:0] C_AND = 4'd1, C_OR = 4'd2, C_XOR = 4'd3, C_CMP = 4'd4;
  localparam logic [3:0] C_TM = 4'd5, C_TRT = 4'd6, C_TS = 4'd7, C_ED = 4'd8;

  logic [MW-1:0] tm_sel;
  logic          sets;
  logic [1:0]    cc_nx;

  assign tm_sel  = opa_i[MW-1:0] & tm_mask_i;
  assign ts_wr_o = load_i && class_i == C_TS;
  assign ts_wb_o = '1;

  always_comb begin
    sets  = 1'b1;
    cc_nx = cc_o;
    case (class_i)
      C_AND: cc_nx = {1'b0, |(opa_i & opb_i)};
      C_OR:  cc_nx = {1'b0, |(opa_i | opb_i)};
      C_XOR: cc_nx = {1'b0, |(opa_i ^ opb_i)};
      C_CMP: cc_nx = (opa_i == opb_i) ? 2'd0 : (opa_i < opb_i) ? 2'd1 : 2'd2;
      C_TM:  cc_nx = (tm_sel == '0) ? 2'd0 : (tm_sel == tm_mask_i) ? 2'd3 : 2'd1;
      C_TRT: cc_nx = !trt_stat_i[1] ? 2'd0 : trt_stat_i[0] ? 2'd2 : 2'd1;
      C_TS:  cc_nx = {1'b0, ts_byte_i[BW-1]};
      C_ED:  cc_nx = !edit_stat_i[1] ? 2'd0 : edit_stat_i[0] ? 2'd1 : 2'd2;
      default: sets = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cc_o <= 2'd0;
    else if (load_i && sets) cc_o <= cc_nx;
endmodule

module logic_cc_unit_chk #(
  parameter int DW = 32,
  parameter int MW = 8,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [3:0]    class_i,
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] opb_i,
  input logic [MW-1:0] tm_mask_i,
  input logic [BW-1:0] ts_byte_i,
  input logic [1:0]    cc_o,
  input logic [BW-1:0] ts_wb_o,
  input logic          ts_wr_o
);
  always_comb if (!rst_n) p_reset_zero_r1: assert (cc_o == 2'd0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i || class_i == 4'd0 || class_i > 4'd8) |=> $stable(cc_o));
  p_and_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && class_i == 4'd1 && (opa_i & opb_i) == '0) |=> cc_o == 2'd0);
  p_cmp_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && class_i == 4'd4 && opa_i == opb_i) |=> cc_o == 2'd0);
  p_tm_nomask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && class_i == 4'd5 && tm_mask_i == '0) |=> cc_o == 2'd0);
  p_ts_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && class_i == 4'd7) |=> cc_o == {1'b0, $past(ts_byte_i[BW-1])});
  p_ts_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wr_o |-> (ts_wb_o == '1 && load_i && class_i == 4'd7));
  p_no_three_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (class_i == 4'd1 || class_i == 4'd3 || class_i == 4'd4 || class_i == 4'd7))
    |=> cc_o != 2'd3);
endmodule

bind logic_cc_unit logic_cc_unit_chk #(.DW(DW), .MW(MW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .class_i(class_i), .opa_i(opa_i),
  .opb_i(opb_i), .tm_mask_i(tm_mask_i), .ts_byte_i(ts_byte_i), .cc_o(cc_o),
  .ts_wb_o(ts_wb_o), .ts_wr_o(ts_wr_o)
);

// File: tb/tb_logic_cc_unit.sv
module tb_logic_cc_unit;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, load = 0;
  logic [3:0] cls = 0;
  logic [31:0] a = 0, b = 0;
  logic [7:0] mask = 0, tsb = 0;
  logic [1:0] trt = 0, ed = 0;
  logic [1:0] cc;
  logic [7:0] wb;
  logic wr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] exp_cc = 0;
  logic [1:0] q_cc[$];
  string q_tag[$];

  logic_cc_unit dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .class_i(cls), .opa_i(a), .opb_i(b),
    .tm_mask_i(mask), .ts_byte_i(tsb), .trt_stat_i(trt), .edit_stat_i(ed),
    .cc_o(cc), .ts_wb_o(wb), .ts_wr_o(wr)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] model(logic [3:0] c, logic [31:0] x, logic [31:0] y,
                                       logic [7:0] m, logic [7:0] t, logic [1:0] s,
                                       logic [1:0] e, logic [1:0] prev);
    logic [7:0] sel = x[7:0] & m;
    case (c)
      1: return ((x & y) == 0) ? 2'd0 : 2'd1;
      2: return ((x | y) == 0) ? 2'd0 : 2'd1;
      3: return ((x ^ y) == 0) ? 2'd0 : 2'd1;
      4: return (x == y) ? 2'd0 : (x < y) ? 2'd1 : 2'd2;
      5: return (m == 0 || sel == 0) ? 2'd0 : (sel == m) ? 2'd3 : 2'd1;
      6: return (s == 2'b00 || s == 2'b01) ? 2'd0 : (s == 2'b10) ? 2'd1 : 2'd2;
      7: return t[7] ? 2'd1 : 2'd0;
      8: return (e[1] == 0) ? 2'd0 : e[0] ? 2'd1 : 2'd2;
      default: return prev;
    endcase
  endfunction

  task automatic op(string tag, logic ld, logic [3:0] c, logic [31:0] x, logic [31:0] y,
                    logic [7:0] m = 0, logic [7:0] t = 0, logic [1:0] s = 0, logic [1:0] e = 0);
    @(negedge clk);
    load = ld; cls = c; a = x; b = y; mask = m; tsb = t; trt = s; ed = e;
    #1;
    chk({tag, " R9 wr"}, wr, ld && c == 4'd7);
    if (ld && c == 4'd7) chk({tag, " R9 byte"}, wb, 8'hFF);
    if (ld) exp_cc = model(c, x, y, m, t, s, e, exp_cc);
    q_cc.push_back(exp_cc);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_cc.size() > 0) chk(q_tag.pop_front(), cc, q_cc.pop_front());
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #(PERIOD * 2 + 1);
    chk("R1 in reset", cc, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", cc, 0);
    op("R3 OR nonzero", 1, 2, 32'h0, 32'h10);
    op("R2 idle hold", 0, 2, 0, 0);
    op("R2 class0 hold", 1, 0, 0, 0);
    op("R2 class9 hold", 1, 9, 0, 0);
    op("R2 class15 hold", 1, 15, 0, 0);
    op("R3 AND zero", 1, 1, 32'hF0F0F0F0, 32'h0F0F0F0F);
    op("R3 AND nonzero R11", 1, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R3 OR zero", 1, 2, 0, 0);
    op("R3 XOR equal", 1, 3, 32'hDEADBEEF, 32'hDEADBEEF);
    op("R3 XOR diff R11", 1, 3, 32'hFFFFFFFF, 32'h0);
    op("R4 equal", 1, 4, 32'h1234, 32'h1234);
    op("R4 low", 1, 4, 32'h1, 32'hFFFFFFFF);
    op("R4 high", 1, 4, 32'h80000000, 32'h7FFFFFFF);
    op("R4 low msb R11", 1, 4, 32'h7FFFFFFF, 32'h80000000);
    op("R2 idle after cmp", 0, 4, 5, 5);
    op("R5 all ones", 1, 5, 32'hFF, 0, 8'hFF);
    op("R5 mixed", 1, 5, 32'h0F, 0, 8'hFF);
    op("R5 all zero", 1, 5, 32'hF0, 0, 8'h0F);
    op("R5 partial ones", 1, 5, 32'hA5, 0, 8'h81);
    op("R5 single set", 1, 5, 32'h08, 0, 8'h08);
    op("R5 single clear", 1, 5, 32'hF7, 0, 8'h08);
    op("R5 ignore upper", 1, 5, 32'hFFFFFF00, 0, 8'hFF);
    op("R5 set before R6", 1, 5, 32'h3, 0, 8'h3);
    op("R6 zero mask", 1, 5, 32'hFF, 0, 8'h00);
    op("R7 none", 1, 6, 0, 0, 0, 0, 2'b00);
    op("R7 early", 1, 6, 0, 0, 0, 0, 2'b10);
    op("R7 last", 1, 6, 0, 0, 0, 0, 2'b11);
    op("R7 last no find", 1, 6, 0, 0, 0, 0, 2'b01);
    op("R8 one", 1, 7, 0, 0, 0, 8'h80);
    op("R8 zero", 1, 7, 0, 0, 0, 8'h7F);
    op("R8 one R11", 1, 7, 0, 0, 0, 8'hFF);
    op("R9 idle no write", 0, 7, 0, 0, 0, 8'h00);
    op("R10 zero", 1, 8, 0, 0, 0, 0, 0, 2'b00);
    op("R10 neg", 1, 8, 0, 0, 0, 0, 0, 2'b11);
    op("R10 pos", 1, 8, 0, 0, 0, 0, 0, 2'b10);
    op("R10 zero negflag", 1, 8, 0, 0, 0, 0, 0, 2'b01);
    op("R5 three again", 1, 5, 32'hFF, 0, 8'hF0);
    op("R2 hold three", 1, 12, 0, 0);
    op("R2 hold idle", 0, 1, 0, 0);
    @(negedge clk);
    load = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule